// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller of a 32-bit load/store processor whose datapath has one ALU and one memory that holds both instructions and data. Every instruction takes several clock cycles. In each cycle the controller sits in one state, and that state alone sets the datapath control lines (a Moore machine). The only inputs that steer it are the 6-bit opcode, which the datapath holds stable from the end of fetch onward, and the ALU overflow flag.

The sequence is as follows. `S_FETCH` reads memory at the PC into the instruction register and adds 4 to the PC. `S_DECODE` computes the branch target and then branches on the opcode class:
- Load and store: `S_MEM_ADDR`, then either `S_LOAD_RD` and `S_LOAD_WB`, or `S_STORE_WR`.
- Register-to-register ALU operations: `S_R_EXEC`, then `S_R_WB`.
- Branch-on-equal: `S_BRANCH`.
- Jump: `S_JUMP`.

Two more states deal with faults. `S_EXC_UNDEF` is entered from decode when the opcode is unknown. `S_EXC_OVF` is entered from `S_R_EXEC` when the ALU reports overflow. Each fault state saves the faulting address, writes a cause code and sends the PC to a fixed handler. Every final state and both fault states go back to `S_FETCH`.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous reset (`rst`=1 at a rising edge) puts the controller in the fetch state. The outputs of the following cycle are the fetch encoding.
- R2: Fetch state encoding:
  - `mem_rd`=1, `ir_we`=1, `mem_addr_sel`=0.
  - `alu_a_sel`=0, `alu_b_sel`=01 (constant 4), `alu_func`=00 (add).
  - `pc_we`=1, `pc_src`=00 (ALU result).
  - Fetch always moves to decode.
- R3: Decode sets `alu_a_sel`=0, `alu_b_sel`=11 (immediate shifted left by 2) and `alu_func`=00. The next state then depends on the opcode:
  - 6'h00 (R-type) goes to R-type execute.
  - 6'h23 (load) and 6'h2B (store) go to address calculation.
  - 6'h04 (branch-on-equal) goes to the branch state.
  - 6'h02 (jump) goes to the jump state.
- R4: Load and store paths:
  - Address calculation sets `alu_a_sel`=1, `alu_b_sel`=10 and `alu_func`=00. It goes to the load read state for 6'h23 and to the store state otherwise.
  - The load read state sets `mem_rd`=1 and `mem_addr_sel`=1, then goes to load writeback.
  - Load writeback sets `rf_we`=1 and `wb_sel_mem`=1 with `rf_dst_rd`=0.
  - The store state sets `mem_wr`=1 and `mem_addr_sel`=1.
  - `mem_rd` and `mem_wr` are never both 1.
- R5: R-type path:
  - R-type execute sets `alu_a_sel`=1, `alu_b_sel`=00 and `alu_func`=10 (function field selects the operation).
  - Without overflow it goes to R-type writeback.
  - R-type writeback sets `rf_we`=1 and `rf_dst_rd`=1 with `wb_sel_mem`=0.
- R6: The branch state sets `alu_a_sel`=1, `alu_b_sel`=00, `alu_func`=01 (subtract), `pc_we_on_zero`=1 and `pc_src`=01 (registered ALU result).
- R7: The jump state sets `pc_we`=1 with `pc_src`=10 (jump address).
- R8: Any opcode other than the five in R3 leads from decode to the undefined-opcode state. That state sets:
  - `exc_pc_we`=1 (save PC-4);
  - `cause_we`=1 with `cause_val`=0;
  - `pc_we`=1 with `pc_src`=11 (handler address 0x80000080).
- R9: Overflow in R-type execute leads to the overflow state instead of writeback, so `rf_we` never rises for the faulting instruction. The overflow state drives the same lines as R8 but with `cause_val`=1. Overflow has no effect in any other state.
- R10: Load writeback, store, R-type writeback, branch, jump and both fault states all return to fetch on the next edge.
- R11: Every control output not named for a state is 0 in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_ovf | input | 1 | ALU signed overflow flag |
| rf_dst_rd | output | 1 | Register write index from rd (1) or rt (0) |
| rf_we | output | 1 | Register file write enable |
| wb_sel_mem | output | 1 | Write-back data from memory data register (1) or ALU result register (0) |
| alu_a_sel | output | 1 | ALU operand A: register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU operand B: 00 reg B, 01 constant 4, 10 immediate, 11 immediate<<2 |
| alu_func | output | 2 | 00 add, 01 subtract, 10 function field |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| mem_addr_sel | output | 1 | Memory address from ALU result register (1) or PC (0) |
| ir_we | output | 1 | Instruction register write enable |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_on_zero | output | 1 | PC write qualified by ALU zero |
| pc_src | output | 2 | 00 ALU, 01 ALU result register, 10 jump address, 11 handler address |
| exc_pc_we | output | 1 | Save PC-4 to the exception address register |
| cause_we | output | 1 | Cause register write enable |
| cause_val | output | 1 | Cause code: 0 undefined opcode, 1 overflow |

## Verification
The hardest case to reach from the ports is an overflow that arrives in exactly the R-type execute cycle. It must divert the machine before writeback. The same flag raised in any other state must do nothing.

The bench holds the overflow flag high for whole instructions of every class. It also mixes unknown opcodes in with the five defined ones. A cycle-by-cycle reference model therefore sees both the diverting case and the many harmless ones.

A reset pulse in the middle of an instruction checks that the return to fetch does not wait for the instruction to finish.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    // State numbering follows the sequence; the value is not decoded outside the block
    typedef enum logic [3:0] {
        S_FETCH     = 4'd0,
        S_DECODE    = 4'd1,
        S_MEM_ADDR  = 4'd2,
        S_LOAD_RD   = 4'd3,
        S_LOAD_WB   = 4'd4,
        S_STORE_WR  = 4'd5,
        S_R_EXEC    = 4'd6,
        S_R_WB      = 4'd7,
        S_BRANCH    = 4'd8,
        S_JUMP      = 4'd9,
        S_EXC_UNDEF = 4'd10,
        S_EXC_OVF   = 4'd11
    } state_t;

    typedef enum logic [2:0] {
        C_RTYPE,
        C_LOAD,
        C_STORE,
        C_BEQ,
        C_JUMP,
        C_UNDEF
    } opclass_t;

    // Operand B select encodings
    localparam logic [1:0] B_REG    = 2'b00;
    localparam logic [1:0] B_FOUR   = 2'b01;
    localparam logic [1:0] B_IMM    = 2'b10;
    localparam logic [1:0] B_IMM_X4 = 2'b11;

    // ALU function encodings
    localparam logic [1:0] F_ADD    = 2'b00;
    localparam logic [1:0] F_SUB    = 2'b01;
    localparam logic [1:0] F_FIELD  = 2'b10;

    // PC source encodings
    localparam logic [1:0] P_ALU    = 2'b00;
    localparam logic [1:0] P_ALUREG = 2'b01;
    localparam logic [1:0] P_JUMP   = 2'b10;
    localparam logic [1:0] P_VECTOR = 2'b11;

    typedef struct packed {
        logic       rf_dst_rd;
        logic       rf_we;
        logic       wb_sel_mem;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_func;
        logic       mem_rd;
        logic       mem_wr;
        logic       mem_addr_sel;
        logic       ir_we;
        logic       pc_we;
        logic       pc_we_on_zero;
        logic [1:0] pc_src;
        logic       exc_pc_we;
        logic       cause_we;
        logic       cause_val;
    } ctrl_t;

endpackage

// File: rtl/mc_opcode_class.sv
module mc_opcode_class
    import mc_ctrl_pkg::*;
#(
    parameter int              OPC_W     = 6,
    parameter logic [OPC_W-1:0] OPC_RTYPE = 6'h00,
    parameter logic [OPC_W-1:0] OPC_JUMP  = 6'h02,
    parameter logic [OPC_W-1:0] OPC_BEQ   = 6'h04,
    parameter logic [OPC_W-1:0] OPC_LOAD  = 6'h23,
    parameter logic [OPC_W-1:0] OPC_STORE = 6'h2B
) (
    input  logic [OPC_W-1:0] opcode,
    output opclass_t         op_class
);

    always_comb begin
        if (opcode == OPC_RTYPE)      op_class = C_RTYPE;
        else if (opcode == OPC_LOAD)  op_class = C_LOAD;
        else if (opcode == OPC_STORE) op_class = C_STORE;
        else if (opcode == OPC_BEQ)   op_class = C_BEQ;
        else if (opcode == OPC_JUMP)  op_class = C_JUMP;
        else                          op_class = C_UNDEF;
    end

endmodule

// File: rtl/mc_state_seq.sv
module mc_state_seq
    import mc_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  opclass_t op_class,
    input  logic     alu_ovf,
    output state_t   state
);

    state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = S_FETCH;
        unique case (state)
            S_FETCH:  state_nx = S_DECODE;
            S_DECODE: begin
                unique case (op_class)
                    C_RTYPE:          state_nx = S_R_EXEC;
                    C_LOAD, C_STORE:  state_nx = S_MEM_ADDR;
                    C_BEQ:            state_nx = S_BRANCH;
                    C_JUMP:           state_nx = S_JUMP;
                    default:          state_nx = S_EXC_UNDEF;
                endcase
            end
            S_MEM_ADDR: state_nx = (op_class == C_LOAD) ? S_LOAD_RD : S_STORE_WR;
            S_LOAD_RD:  state_nx = S_LOAD_WB;
            S_R_EXEC:   state_nx = alu_ovf ? S_EXC_OVF : S_R_WB;
            S_LOAD_WB, S_STORE_WR, S_R_WB, S_BRANCH, S_JUMP,
            S_EXC_UNDEF, S_EXC_OVF:
                        state_nx = S_FETCH;
            default:    state_nx = S_FETCH;
        endcase
    end

    // R4: address calculation for a load continues to the read cycle
    a_r4_load_path: assert property (@(posedge clk) disable iff (rst)
        (state == S_MEM_ADDR && op_class == C_LOAD) |=> (state == S_LOAD_RD));

    // R9: overflow in execute diverts to the fault state
    a_r9_ovf_divert: assert property (@(posedge clk) disable iff (rst)
        (state == S_R_EXEC && alu_ovf) |=> (state == S_EXC_OVF));

    // R10: terminal states return to fetch
    a_r10_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (state inside {S_LOAD_WB, S_STORE_WR, S_R_WB, S_BRANCH, S_JUMP,
                       S_EXC_UNDEF, S_EXC_OVF}) |=> (state == S_FETCH));

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  state_t state,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (state)
            S_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_we     = 1'b1;
                ctrl.alu_b_sel = B_FOUR;
                ctrl.alu_func  = F_ADD;
                ctrl.pc_we     = 1'b1;
                ctrl.pc_src    = P_ALU;
            end
            S_DECODE: begin
                ctrl.alu_b_sel = B_IMM_X4;
                ctrl.alu_func  = F_ADD;
            end
            S_MEM_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = B_IMM;
                ctrl.alu_func  = F_ADD;
            end
            S_LOAD_RD: begin
                ctrl.mem_rd       = 1'b1;
                ctrl.mem_addr_sel = 1'b1;
            end
            S_LOAD_WB: begin
                ctrl.rf_we      = 1'b1;
                ctrl.wb_sel_mem = 1'b1;
            end
            S_STORE_WR: begin
                ctrl.mem_wr       = 1'b1;
                ctrl.mem_addr_sel = 1'b1;
            end
            S_R_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = B_REG;
                ctrl.alu_func  = F_FIELD;
            end
            S_R_WB: begin
                ctrl.rf_we     = 1'b1;
                ctrl.rf_dst_rd = 1'b1;
            end
            S_BRANCH: begin
                ctrl.alu_a_sel     = 1'b1;
                ctrl.alu_b_sel     = B_REG;
                ctrl.alu_func      = F_SUB;
                ctrl.pc_we_on_zero = 1'b1;
                ctrl.pc_src        = P_ALUREG;
            end
            S_JUMP: begin
                ctrl.pc_we  = 1'b1;
                ctrl.pc_src = P_JUMP;
            end
            S_EXC_UNDEF, S_EXC_OVF: begin
                ctrl.pc_we     = 1'b1;
                ctrl.pc_src    = P_VECTOR;
                ctrl.exc_pc_we = 1'b1;
                ctrl.cause_we  = 1'b1;
                ctrl.cause_val = (state == S_EXC_OVF);
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int              OPC_W     = 6,
    parameter logic [OPC_W-1:0] OPC_RTYPE = 6'h00,
    parameter logic [OPC_W-1:0] OPC_JUMP  = 6'h02,
    parameter logic [OPC_W-1:0] OPC_BEQ   = 6'h04,
    parameter logic [OPC_W-1:0] OPC_LOAD  = 6'h23,
    parameter logic [OPC_W-1:0] OPC_STORE = 6'h2B
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_ovf,
    output logic             rf_dst_rd,
    output logic             rf_we,
    output logic             wb_sel_mem,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic [1:0]       alu_func,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             mem_addr_sel,
    output logic             ir_we,
    output logic             pc_we,
    output logic             pc_we_on_zero,
    output logic [1:0]       pc_src,
    output logic             exc_pc_we,
    output logic             cause_we,
    output logic             cause_val
);

    opclass_t op_class;
    state_t   state;
    ctrl_t    ctrl;

    mc_opcode_class #(
        .OPC_W     (OPC_W),
        .OPC_RTYPE (OPC_RTYPE),
        .OPC_JUMP  (OPC_JUMP),
        .OPC_BEQ   (OPC_BEQ),
        .OPC_LOAD  (OPC_LOAD),
        .OPC_STORE (OPC_STORE)
    ) u_class (
        .opcode   (opcode),
        .op_class (op_class)
    );

    mc_state_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .op_class (op_class),
        .alu_ovf  (alu_ovf),
        .state    (state)
    );

    mc_ctrl_decode u_dec (
        .state (state),
        .ctrl  (ctrl)
    );

    assign rf_dst_rd     = ctrl.rf_dst_rd;
    assign rf_we         = ctrl.rf_we;
    assign wb_sel_mem    = ctrl.wb_sel_mem;
    assign alu_a_sel     = ctrl.alu_a_sel;
    assign alu_b_sel     = ctrl.alu_b_sel;
    assign alu_func      = ctrl.alu_func;
    assign mem_rd        = ctrl.mem_rd;
    assign mem_wr        = ctrl.mem_wr;
    assign mem_addr_sel  = ctrl.mem_addr_sel;
    assign ir_we         = ctrl.ir_we;
    assign pc_we         = ctrl.pc_we;
    assign pc_we_on_zero = ctrl.pc_we_on_zero;
    assign pc_src        = ctrl.pc_src;
    assign exc_pc_we     = ctrl.exc_pc_we;
    assign cause_we      = ctrl.cause_we;
    assign cause_val     = ctrl.cause_val;

    // R1: reset leads to the fetch encoding
    a_r1_reset_fetch: assert property (@(posedge clk)
        rst |=> (ir_we && mem_rd && pc_we));

    // R4: memory is never read and written in the same cycle
    a_r4_mem_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R8: unknown opcode at decode raises cause 0 next cycle
    a_r8_undef_cause: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE && op_class == C_UNDEF)
        |=> (cause_we && !cause_val && exc_pc_we && pc_src == P_VECTOR));

    // R9: faulting R-type never writes the register file
    a_r9_no_rf_write: assert property (@(posedge clk) disable iff (rst)
        (state == S_R_EXEC && alu_ovf) |=> (!rf_we && cause_we && cause_val));

    // R10: a fault cycle is followed by fetch
    a_r10_fault_refetch: assert property (@(posedge clk) disable iff (rst)
        cause_we |=> ir_we);

endmodule

// File: tb/mc_ctrl_fsm_bench.sv
module mc_ctrl_fsm_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] opcode;
    logic       alu_ovf;
    logic       rf_dst_rd, rf_we, wb_sel_mem, alu_a_sel;
    logic [1:0] alu_b_sel, alu_func, pc_src;
    logic       mem_rd, mem_wr, mem_addr_sel, ir_we, pc_we, pc_we_on_zero;
    logic       exc_pc_we, cause_we, cause_val;

    int n_cmp = 0;
    int n_bad = 0;
    int m_state = 0;
    int m_prev  = 0;
    bit reset_chk = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mc_ctrl_fsm u_mc_ctrl_fsm (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf),
        .rf_dst_rd(rf_dst_rd), .rf_we(rf_we), .wb_sel_mem(wb_sel_mem),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_func(alu_func),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_sel(mem_addr_sel),
        .ir_we(ir_we), .pc_we(pc_we), .pc_we_on_zero(pc_we_on_zero),
        .pc_src(pc_src), .exc_pc_we(exc_pc_we), .cause_we(cause_we),
        .cause_val(cause_val)
    );

    wire [18:0] actual = {rf_dst_rd, rf_we, wb_sel_mem, alu_a_sel, alu_b_sel,
                          alu_func, mem_rd, mem_wr, mem_addr_sel, ir_we, pc_we,
                          pc_we_on_zero, pc_src, exc_pc_we, cause_we, cause_val};

    // Expected lines per state, from the requirements (unnamed lines are 0: R11)
    function automatic logic [18:0] expv(input int s);
        logic dst, rfw, wbm, asel, mrd, mwr, msel, irw, pcw, pcz, epw, cw, cv;
        logic [1:0] bsel, fn, psrc;
        {dst, rfw, wbm, asel, mrd, mwr, msel, irw, pcw, pcz, epw, cw, cv} = '0;
        bsel = 2'b00; fn = 2'b00; psrc = 2'b00;
        case (s)
            0:  begin mrd = 1; irw = 1; bsel = 2'b01; pcw = 1; end
            1:  bsel = 2'b11;
            2:  begin asel = 1; bsel = 2'b10; end
            3:  begin mrd = 1; msel = 1; end
            4:  begin rfw = 1; wbm = 1; end
            5:  begin mwr = 1; msel = 1; end
            6:  begin asel = 1; fn = 2'b10; end
            7:  begin rfw = 1; dst = 1; end
            8:  begin asel = 1; fn = 2'b01; pcz = 1; psrc = 2'b01; end
            9:  begin pcw = 1; psrc = 2'b10; end
            10: begin pcw = 1; psrc = 2'b11; epw = 1; cw = 1; end
            11: begin pcw = 1; psrc = 2'b11; epw = 1; cw = 1; cv = 1; end
            default: ;
        endcase
        return {dst, rfw, wbm, asel, bsel, fn, mrd, mwr, msel, irw, pcw,
                pcz, psrc, epw, cw, cv};
    endfunction

    function automatic int nxt(input int s, input logic [5:0] op, input logic ov);
        case (s)
            0: return 1;
            1: begin
                if (op == 6'h00) return 6;
                if (op == 6'h02) return 9;
                if (op == 6'h04) return 8;
                if (op == 6'h23 || op == 6'h2B) return 2;
                return 10;
            end
            2: return (op == 6'h23) ? 3 : 5;
            3: return 4;
            6: return ov ? 11 : 7;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input int s, input int p, input bit r);
        if (r) return "R1";
        if (s == 0 && p != 0) return "R10";
        case (s)
            0: return "R2";
            1: return "R3";
            2, 3, 4, 5: return "R4";
            6, 7: return "R5";
            8: return "R6";
            9: return "R7";
            10: return "R8";
            11: return "R9";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        m_prev  <= m_state;
        if (rst) m_state <= 0;
        else     m_state <= nxt(m_state, opcode, alu_ovf);
    end

    task automatic tick();
        logic [18:0] e;
        @(negedge clk);
        e = expv(m_state);
        n_cmp++;
        if (actual !== e) begin
            n_bad++;
            $display("FAIL %s/R11 state=%0d actual=%b expected=%b",
                     req_of(m_state, m_prev, reset_chk), m_state, actual, e);
        end
    endtask

    // Runs one instruction from fetch back to fetch, flag held throughout
    task automatic exec(input logic [5:0] op, input logic ov);
        opcode  = op;
        alu_ovf = ov;
        tick();
        while (m_state != 0) tick();
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 200000; wd++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; opcode = 6'h00; alu_ovf = 1'b0;
        reset_chk = 1'b1;
        tick();             // R1: fetch encoding after reset edge
        tick();
        reset_chk = 1'b0;
        rst = 1'b0;
        // Directed: each class with and without overflow (R2..R10)
        exec(6'h23, 1'b0);  // load R4
        exec(6'h2B, 1'b0);  // store R4
        exec(6'h00, 1'b0);  // R-type R5
        exec(6'h00, 1'b1);  // R-type overflow R9
        exec(6'h04, 1'b0);  // branch R6
        exec(6'h02, 1'b0);  // jump R7
        exec(6'h01, 1'b0);  // undefined R8
        exec(6'h3F, 1'b0);  // undefined R8
        exec(6'h2A, 1'b1);  // undefined with overflow R8
        exec(6'h23, 1'b1);  // overflow ignored on load R9
        exec(6'h2B, 1'b1);  // overflow ignored on store R9
        exec(6'h04, 1'b1);  // overflow ignored on branch R9
        exec(6'h02, 1'b1);  // overflow ignored on jump R9
        // Reset in the middle of a load (R1)
        opcode = 6'h23; alu_ovf = 1'b0;
        tick(); tick();
        rst = 1'b1; reset_chk = 1'b1;
        tick();
        rst = 1'b0; reset_chk = 1'b0;
        exec(6'h00, 1'b0);
        // Random mix
        for (int i = 0; i < 1500; i++) begin
            logic [5:0] op;
            case ($urandom % 7)
                0: op = 6'h00;
                1: op = 6'h02;
                2: op = 6'h04;
                3: op = 6'h23;
                4: op = 6'h2B;
                default: op = 6'($urandom);
            endcase
            exec(op, ($urandom % 3) == 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule